// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block drives one pulse-width modulated output from a small register set on a plain memory-mapped port. Software writes a period value, a prescaler and an output mode. It then pushes duty samples into a four-deep queue. An up-counter, advanced by a prescaled clock-enable, runs from zero to the period value plus one and then wraps. The output sits at its active level while the count is below the sample now in use.

The counter takes a new sample from the queue only at a wrap. This happens once the current sample has served its chosen number of periods (1, 2, 4 or 8). When the queue is empty the last sample keeps running, so a steady duty needs one write only. Status bits report the queue level, queue empty, counter wrap, compare match and a write into a full queue. A self-clearing soft reset returns the registers to their reset values and empties the queue.

Top module: `fifo_pwm`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, the status register (offset 0x04) reads 0x08, the period register (offset 0x10) reads 0xFFFE, and the output is 0.
- R2: In normal mode with prescale divide D, period value P and sample S, each output period lasts (P+2)·D clock cycles, and the output is high for min(S, P+2)·D of them.
- R3: Control bits 15:4 hold the prescaler field F, which gives a divide of F+1. The counter moves only on cycles where tick_en is high.
- R4: A period value of 0xFFFF gives exactly the timing of 0xFFFE.
- R5: Control bits 19:18 select the output mode: 0 is normal, 1 is inverted, and 2 or 3 force the output low.
- R6: While the enable bit (control bit 0) is 0, the output is 0 in every mode.
- R7: Writing control with bit 3 set starts a soft reset. Bit 3 reads 1 for SWR_CYCLES cycles and the other control fields read 0. Afterwards control reads 0, period reads 0xFFFE and the queue is empty.
- R8: The sample queue (written at offset 0x0C) holds up to four words. Status bits 2:0 give the fill level and status bit 3 is set when the level is 0.
- R9: A sample write while the queue holds four words drops the word and sets status bit 6.
- R10: Control bits 2:1 = k make each sample serve 2^k periods. The first sample is taken the cycle after enable, and later ones only at a wrap. When the queue is empty at that point, the current sample stays.
- R11: Reading offset 0x0C returns the sample in use while enabled and 0 while disabled.
- R12: Status bit 4 (wrap) and bit 5 (compare match) are set by the counter only while running. Writing 1 to status bits 4, 5 or 6 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counting clock enable feeding the prescaler |
| busWr | input | 1 | Write strobe for the register port |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, no read side effects |
| pwmOut | output | 1 | Modulated output |

## Verification
On every cycle the assertions check these properties:
- the output is low while disabled and in the forced-off modes;
- a soft-reset write starts the flush, and the queue is empty once the flush begins;
- the sample register reads zero while disabled;
- wrap events happen only while running.

Only the bench's scenarios can show the rest:
- the waveform timing under each prescale, period and sample mix;
- the clamp of 0xFFFF;
- how long each sample lasts under the repeat settings;
- the dropped word on overflow;
- the write-one-to-clear behaviour of the flags.

// File: rtl/fifo_pwm_pkg.sv
`timescale 1ns/1ps
package fifo_pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 12;
  localparam int RPT_W  = 2;
  localparam int REP_W  = (1 << RPT_W) - 1;  // holds counts up to 2^(2^RPT_W - 1) - 1

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_SAMP = 'h0C;
  localparam int OFS_PER  = 'h10;

  localparam logic [CNT_W-1:0] PER_MAX   = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] PER_RESET = PER_MAX;

  typedef enum logic [1:0] {
    OUT_NORMAL = 2'd0,
    OUT_INVERT = 2'd1,
    OUT_OFF    = 2'd2,
    OUT_OFF_B  = 2'd3
  } outMode_e;

  typedef struct packed {
    logic             run;
    logic             flush;
    logic [PRE_W-1:0] presc;
    logic [RPT_W-1:0] rptSel;
    outMode_e         mode;
    logic [CNT_W-1:0] period;
    logic             headValid;
    logic [CNT_W-1:0] headData;
  } ctlToDp_t;

  typedef struct packed {
    logic             popReq;
    logic             rollEv;
    logic             cmpEv;
    logic [CNT_W-1:0] sample;
  } dpToCtl_t;
endpackage

// File: rtl/fifo_pwm_ctrl.sv
`timescale 1ns/1ps
module fifo_pwm_ctrl
  import fifo_pwm_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,   // power of two
  parameter int SWR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  dpToCtl_t          fromDp,
  output ctlToDp_t          toDp
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int SWR_W = $clog2(SWR_CYCLES + 1);

  logic             enBit;
  logic [RPT_W-1:0] rptSel;
  logic [PRE_W-1:0] presc;
  outMode_e         mode;
  logic [CNT_W-1:0] periodReg;
  logic [SWR_W-1:0] swrCnt;
  logic             rollFlag, cmpFlag, werrFlag;

  logic [CNT_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] level;

  logic swrBusy, selCtrl, selStat, selSamp, selPer;
  logic wrCtrl, wrStat, wrSamp, wrPer;
  logic full, push, pop;

  assign swrBusy = (swrCnt != '0);
  assign selCtrl = (busAddr == ADDR_W'(OFS_CTRL));
  assign selStat = (busAddr == ADDR_W'(OFS_STAT));
  assign selSamp = (busAddr == ADDR_W'(OFS_SAMP));
  assign selPer  = (busAddr == ADDR_W'(OFS_PER));
  assign wrCtrl  = busWr && selCtrl && !swrBusy;
  assign wrStat  = busWr && selStat && !swrBusy;
  assign wrSamp  = busWr && selSamp && !swrBusy;
  assign wrPer   = busWr && selPer  && !swrBusy;

  assign full = (level == LVL_W'(FIFO_DEPTH));
  assign push = wrSamp && !full;
  assign pop  = fromDp.popReq && (level != '0) && !swrBusy;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= busWdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      rptSel    <= '0;
      presc     <= '0;
      mode      <= OUT_NORMAL;
      periodReg <= PER_RESET;
      swrCnt    <= '0;
      rollFlag  <= 1'b0;
      cmpFlag   <= 1'b0;
      werrFlag  <= 1'b0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      level     <= '0;
    end else if (swrBusy) begin
      swrCnt    <= swrCnt - SWR_W'(1);
      enBit     <= 1'b0;
      rptSel    <= '0;
      presc     <= '0;
      mode      <= OUT_NORMAL;
      periodReg <= PER_RESET;
      rollFlag  <= 1'b0;
      cmpFlag   <= 1'b0;
      werrFlag  <= 1'b0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      level     <= '0;
    end else begin
      if (wrCtrl) begin
        if (busWdata[3]) begin
          swrCnt <= SWR_W'(SWR_CYCLES);
          enBit  <= 1'b0;
          rptSel <= '0;
          presc  <= '0;
          mode   <= OUT_NORMAL;
        end else begin
          enBit  <= busWdata[0];
          rptSel <= busWdata[2:1];
          presc  <= busWdata[15:4];
          mode   <= outMode_e'(busWdata[19:18]);
        end
      end
      if (wrPer) periodReg <= busWdata[CNT_W-1:0];
      rollFlag <= fromDp.rollEv | (rollFlag & ~(wrStat & busWdata[4]));
      cmpFlag  <= fromDp.cmpEv  | (cmpFlag  & ~(wrStat & busWdata[5]));
      werrFlag <= (wrSamp & full) | (werrFlag & ~(wrStat & busWdata[6]));
      if (push) wrPtr <= wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= rdPtr + PTR_W'(1);
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  always_comb begin
    toDp.run       = enBit;
    toDp.flush     = swrBusy;
    toDp.presc     = presc;
    toDp.rptSel    = rptSel;
    toDp.mode      = mode;
    toDp.period    = (periodReg > PER_MAX) ? PER_MAX : periodReg;
    toDp.headValid = (level != '0);
    toDp.headData  = mem[rdPtr];
  end

  always_comb begin
    busRdata = '0;
    if (selCtrl) begin
      busRdata[0]     = enBit;
      busRdata[2:1]   = rptSel;
      busRdata[3]     = swrBusy;
      busRdata[15:4]  = presc;
      busRdata[19:18] = mode;
    end else if (selStat) begin
      busRdata[2:0] = 3'(level);
      busRdata[3]   = (level == '0);
      busRdata[4]   = rollFlag;
      busRdata[5]   = cmpFlag;
      busRdata[6]   = werrFlag;
    end else if (selSamp) begin
      busRdata[CNT_W-1:0] = enBit ? fromDp.sample : '0;
    end else if (selPer) begin
      busRdata[CNT_W-1:0] = periodReg;
    end
  end
endmodule

// File: rtl/fifo_pwm_dp.sv
`timescale 1ns/1ps
module fifo_pwm_dp
  import fifo_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  ctlToDp_t cmd,
  output dpToCtl_t evt,
  output logic     pwmOut
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cnt, cntNext, topVal, actSample;
  logic [REP_W-1:0] repCnt, rptLast;
  logic             primed, prime, step, wrap, repDone, activeLvl;

  assign rptLast = REP_W'(((REP_W+1)'(1) << cmd.rptSel) - (REP_W+1)'(1));
  assign topVal  = cmd.period + CNT_W'(1);
  assign prime   = cmd.run && !cmd.flush && !primed;
  assign step    = cmd.run && !cmd.flush && primed && tickEn && (preCnt >= cmd.presc);
  assign wrap    = step && (cnt == topVal);
  assign cntNext = wrap ? '0 : cnt + CNT_W'(1);
  assign repDone = (repCnt == rptLast);

  always_comb begin
    evt.popReq = prime || (wrap && repDone);
    evt.rollEv = wrap;
    evt.cmpEv  = step && (cntNext == actSample);
    evt.sample = actSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      cnt       <= '0;
      repCnt    <= '0;
      primed    <= 1'b0;
      actSample <= '0;
    end else if (cmd.flush || !cmd.run) begin
      preCnt <= '0;
      cnt    <= '0;
      repCnt <= '0;
      primed <= 1'b0;
      if (cmd.flush) actSample <= '0;
    end else begin
      if (prime) primed <= 1'b1;
      if (tickEn && primed)
        preCnt <= (preCnt >= cmd.presc) ? '0 : preCnt + PRE_W'(1);
      if (step) cnt <= cntNext;
      if (wrap) repCnt <= repDone ? '0 : repCnt + REP_W'(1);
      if (evt.popReq && cmd.headValid) actSample <= cmd.headData;
    end
  end

  assign activeLvl = (cnt < actSample);

  always_comb begin
    pwmOut = 1'b0;
    if (cmd.run) begin
      unique case (cmd.mode)
        OUT_NORMAL: pwmOut = activeLvl;
        OUT_INVERT: pwmOut = ~activeLvl;
        default:    pwmOut = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fifo_pwm.sv
`timescale 1ns/1ps
module fifo_pwm
  import fifo_pwm_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int SWR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pwmOut
);
  ctlToDp_t toDp;
  dpToCtl_t fromDp;

  fifo_pwm_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH), .SWR_CYCLES(SWR_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .fromDp(fromDp), .toDp(toDp)
  );

  fifo_pwm_dp u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cmd(toDp), .evt(fromDp), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/fifo_pwm_chk.sv
`timescale 1ns/1ps
module fifo_pwm_chk
  import fifo_pwm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              pwmOut,
  input ctlToDp_t          toDp,
  input dpToCtl_t          fromDp
);
  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !toDp.run |-> !pwmOut);

  // R5
  forced_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toDp.mode == OUT_OFF || toDp.mode == OUT_OFF_B) |-> !pwmOut);

  // R7
  swr_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFS_CTRL) && busWdata[3] && !toDp.flush) |=> toDp.flush);

  // R7
  swr_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    toDp.flush |=> !toDp.headValid);

  // R11
  samp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!toDp.run && busAddr == ADDR_W'(OFS_SAMP)) |-> (busRdata == '0));

  // R12
  wrap_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    fromDp.rollEv |-> toDp.run);
endmodule

bind fifo_pwm fifo_pwm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .pwmOut(pwmOut), .toDp(toDp), .fromDp(fromDp)
);

// File: tb/fifo_pwm_bench.sv
`timescale 1ns/1ps
module fifo_pwm_bench;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int SWR_CYCLES = 4;
  localparam int WD_CYCLES = 190000;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

  // stimulus / expected table: period, sample, prescaler field, mode, window, expected high cycles
  localparam int NV = 7;
  localparam int T_PER [NV] = '{6, 6, 10, 4, 6, 6, 'hFFFF};
  localparam int T_SMP [NV] = '{3, 3,  4, 9, 0, 3, 'hFFFF};
  localparam int T_PRE [NV] = '{0, 0,  2, 0, 0, 1, 0};
  localparam int T_MOD [NV] = '{0, 1,  0, 0, 0, 2, 0};
  localparam int T_LEN [NV] = '{8, 8, 36, 6, 8, 16, 65536};
  localparam int T_HI  [NV] = '{3, 5, 12, 6, 0, 0, 65535};

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b1, busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0, busRdata;
  logic pwmOut;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  fifo_pwm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SWR_CYCLES(SWR_CYCLES)) u_fifo_pwm (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic softRst();
    wr(A_CTRL, 32'h8);
    repeat (SWR_CYCLES + 2) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    int hi, cntA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); chk("R1 status", v, 32'h8);
    rd(A_PER, v);  chk("R1 period", v, 32'hFFFE);
    chk("R1 out", {31'b0, pwmOut}, 32'h0);

    // R7 soft reset
    wr(A_PER, 32'd20); wr(A_SAMP, 32'd7); wr(A_CTRL, 32'h4_0050);
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v); chk("R7 busy", v, 32'h8);
    repeat (SWR_CYCLES + 2) @(negedge clk);
    rd(A_CTRL, v); chk("R7 ctrl cleared", v, 32'h0);
    rd(A_PER, v);  chk("R7 period", v, 32'hFFFE);
    rd(A_STAT, v); chk("R7 queue empty", v, 32'h8);

    // R6 R11 disabled with inverted mode and a queued sample
    wr(A_SAMP, 32'd3); wr(A_CTRL, 32'h4_0000);
    repeat (4) @(negedge clk);
    chk("R6 disabled inverted out", {31'b0, pwmOut}, 32'h0);
    rd(A_SAMP, v); chk("R11 disabled read", v, 32'h0);
    rd(A_STAT, v); chk("R8 level one", v, 32'h1);

    // R8 R9 overflow
    softRst();
    for (int k = 0; k < 5; k++) wr(A_SAMP, 32'(10 + k));
    rd(A_STAT, v); chk("R9 full plus error", v, 32'h44);
    wr(A_PER, 32'd6); wr(A_CTRL, 32'h1);
    repeat (60) @(negedge clk);
    rd(A_SAMP, v); chk("R9 dropped word", v, 32'd13);
    rd(A_STAT, v); chk("R8 drained", v & 32'hF, 32'h8);

    // R10 repeat counts
    for (int r = 0; r < 4; r++) begin
      softRst();
      wr(A_PER, 32'd6); wr(A_SAMP, 32'd2); wr(A_SAMP, 32'd5);
      wr(A_CTRL, 32'((r << 1) | 1));
      cntA = 0;
      for (int c = 0; c < 72; c++) begin
        rd(A_SAMP, v);
        if (v == 32'd2) cntA++;
      end
      chk("R10 periods per sample", 32'(cntA), 32'(8 << r));
      rd(A_SAMP, v); chk("R10 last sample kept", v, 32'd5);
    end

    // R12 R11 flags and enabled readback
    softRst();
    wr(A_PER, 32'd6); wr(A_SAMP, 32'd3); wr(A_CTRL, 32'h1);
    repeat (20) @(negedge clk);
    rd(A_SAMP, v); chk("R11 enabled read", v, 32'd3);
    rd(A_STAT, v); chk("R12 flags set", v & 32'h70, 32'h30);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h70);
    rd(A_STAT, v); chk("R12 flags cleared", v & 32'h70, 32'h0);

    // R3 tick enable gating: half-rate ticks double the period
    softRst();
    wr(A_PER, 32'd6); wr(A_SAMP, 32'd3); wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    hi = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      tickEn = ~tickEn;
      if (pwmOut) hi++;
    end
    tickEn = 1'b1;
    chk("R3 tick gating", 32'(hi), 32'd6);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      softRst();
      wr(A_PER, 32'(T_PER[i]));
      wr(A_SAMP, 32'(T_SMP[i]));
      wr(A_CTRL, 32'((T_MOD[i] << 18) | (T_PRE[i] << 4) | 1));
      repeat (3) @(negedge clk);
      hi = 0;
      for (int c = 0; c < T_LEN[i]; c++) begin
        @(negedge clk);
        if (pwmOut) hi++;
      end
      chk($sformatf("R2 R3 R4 R5 vector %0d", i), 32'(hi), 32'(T_HI[i]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule